// File: doc/BRIEF.md
# Temperature-Indexed Voltage Lookup Mapper

This block turns a freshly converted temperature into the code for an output voltage DAC. The temperature arrives as a 9-bit two's-complement value with a least significant bit of 0.5 °C. The block clamps it into the mapped window of -25.0 °C to +100.0 °C, which holds 251 entries. It then turns the clamped value into a page number and a bit offset inside a paged table memory. Each page is 80 bits wide and each entry is a 10-bit word. The block fetches that word over a request/acknowledge port and registers it as the DAC code. The analog stage later produces 1.280 V plus the code times 5 mV, so code 000h gives 1.280 V and 3FFh gives 6.395 V.

The table layout is irregular. There are 33 pages, 00h to 20h. Page 00h carries only the two coldest entries, in its top two slots, and its other 60 bits belong to the user. Every page from 01h to 1Fh holds eight consecutive half-degree entries. Page 20h holds only the +100.0 °C entry, in slot 0.

The controller has two states. ST_IDLE waits for a new result. ST_FETCH holds the memory request until the acknowledge arrives. There are four transitions:
- IDLE_TO_FETCH: a result strobe arrives while output is enabled.
- FETCH_WAIT: no acknowledge yet, so the state stays in ST_FETCH.
- FETCH_CHAIN: acknowledge arrives with a newer result waiting and output still enabled, so the next fetch starts at once.
- FETCH_TO_IDLE: acknowledge arrives with nothing waiting.

Top module: `tmap_top`

## Requirements
- R1: After reset, dac_code is 0, dac_valid is 0 and mem_req is 0.
- R2: A one-cycle temp_valid with out_en=1 in ST_IDLE raises mem_req on the next cycle. mem_req, mem_page and mem_bitoff then hold steady until the cycle in which mem_ack is 1.
- R3: temp_in is two's complement in 0.5 °C steps. For a value h (in half-degrees) with -50 <= h <= 200, let p = h + 56. The block requests mem_page = p >> 3 and mem_bitoff = (p & 7) * 10. Examples:
  - 1CEh (-25.0 °C) gives page 0, offset 60.
  - 1CFh (-24.5 °C) gives page 0, offset 70.
  - 1D0h (-24.0 °C) gives page 1, offset 0.
  - 033h (+25.5 °C) gives page 13, offset 30.
  - 0C8h (+100.0 °C) gives page 32, offset 0.
- R4: Any temperature below -25.0 °C (for example 192h, -55 °C, or 1CDh, -25.5 °C) requests page 0, offset 60.
- R5: Any temperature above +100.0 °C (for example 0FAh, +125 °C, or 0C9h, +100.5 °C) requests page 32, offset 0.
- R6: In a cycle with mem_req=1, mem_ack=1 and out_en=1, the block loads mem_rdata into dac_code and sets dac_valid to 1, effective the next cycle. At no other time does dac_code change.
- R7: While out_en=0:
  - dac_valid is 0 from the next cycle on.
  - dac_code holds its value.
  - A temp_valid seen in ST_IDLE starts no fetch.
- R8: If out_en is 0 in the acknowledge cycle of a fetch already under way, the fetched word is discarded and dac_code keeps its old value.
- R9: Results that arrive during a fetch are not lost. Only the most recent of them is kept, and it is fetched as soon as the current fetch completes. Earlier ones are superseded and never fetched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| temp_valid | input | 1 | One-cycle strobe: a new temperature has been latched |
| temp_in | input | 9 | Temperature, two's complement, 0.5 °C per LSB |
| out_en | input | 1 | Analog output enable |
| mem_req | output | 1 | Table read request, held until acknowledged |
| mem_page | output | 6 | Page number of the requested entry |
| mem_bitoff | output | 7 | Bit offset of the entry within its 80-bit page |
| mem_ack | input | 1 | One-cycle acknowledge; mem_rdata is valid with it |
| mem_rdata | input | 10 | Table word returned by the memory |
| dac_code | output | 10 | Registered DAC code |
| dac_valid | output | 1 | dac_code holds a word fetched while output was enabled |

## Verification
The bench builds the block with its defaults: 9-bit temperatures, 10-bit words, eight slots per 80-bit page, 33 pages and a window of -50 to +200 half-degrees. Its memory model answers after three cycles. That latency leaves room to stack several strobes inside a single fetch, and so to reach the case where a newer result supersedes an older one. A 9-bit input has only 512 codes, so the bench sweeps every one of them. The sweep covers both clamp regions, both partial pages and every slot of every full page.

// File: rtl/tmap_pkg.sv
package tmap_pkg;
    localparam int TEMP_W_D    = 9;
    localparam int WORD_W_D    = 10;
    localparam int SLOTS_D     = 8;
    localparam int PAGE_BITS_D = 80;
    localparam int PAGE_CNT_D  = 33;
    localparam int LO_HALF_D   = -50;
    localparam int HI_HALF_D   = 200;
    localparam int SKEW_D      = 6;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_FETCH = 1'b1
    } tmap_state_e;
endpackage

// File: rtl/tmap_addr.sv
module tmap_addr #(
    parameter int TEMP_W   = 9,
    parameter int WORD_W   = 10,
    parameter int SLOTS    = 8,
    parameter int LO_HALF  = -50,
    parameter int HI_HALF  = 200,
    parameter int SKEW     = 6,
    parameter int PG_W     = 6,
    parameter int OFF_W    = 7
) (
    input  logic [TEMP_W-1:0] temp,
    output logic [PG_W-1:0]   page,
    output logic [OFF_W-1:0]  bit_off
);
    localparam int EXT_W  = TEMP_W + 2;
    localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam logic signed [EXT_W-1:0] LO_C   = EXT_W'(LO_HALF);
    localparam logic signed [EXT_W-1:0] HI_C   = EXT_W'(HI_HALF);
    localparam logic signed [EXT_W-1:0] BASE_C = EXT_W'(SKEW - LO_HALF);

    logic signed [EXT_W-1:0] t_ext;
    logic signed [EXT_W-1:0] t_cl;
    logic        [EXT_W-1:0] pos;
    logic        [SLOT_W-1:0] slot;

    // clamp into the mapped window, then shift so the coldest entry lands at its skewed slot
    always_comb begin
        t_ext = EXT_W'($signed(temp));
        if (t_ext < LO_C)      t_cl = LO_C;
        else if (t_ext > HI_C) t_cl = HI_C;
        else                   t_cl = t_ext;
        pos = $unsigned(t_cl + BASE_C);
    end

    // power-of-two page depth splits by bit slicing; other depths divide
    generate
        if ((SLOTS & (SLOTS - 1)) == 0) begin : g_pow2
            always_comb begin
                slot = pos[SLOT_W-1:0];
                page = PG_W'(pos >> SLOT_W);
            end
        end else begin : g_div
            always_comb begin
                slot = SLOT_W'(pos % EXT_W'(SLOTS));
                page = PG_W'(pos / EXT_W'(SLOTS));
            end
        end
    endgenerate

    assign bit_off = OFF_W'(32'(slot) * WORD_W);
endmodule

// File: rtl/tmap_ctrl.sv
module tmap_ctrl
    import tmap_pkg::*;
#(
    parameter int TEMP_W = 9,
    parameter int WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              temp_valid,
    input  logic [TEMP_W-1:0] temp_in,
    input  logic              out_en,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [TEMP_W-1:0] cur_temp,
    output logic              mem_req,
    output logic [WORD_W-1:0] dac_code,
    output logic              dac_valid
);
    tmap_state_e         state, state_nx;
    logic [TEMP_W-1:0]   pend_temp;
    logic                pend_vld;
    logic                take;
    logic                chain;

    assign take  = temp_valid && out_en;
    assign chain = out_en && (take || pend_vld);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions: IDLE_TO_FETCH, FETCH_WAIT, FETCH_CHAIN, FETCH_TO_IDLE
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (take) state_nx = ST_FETCH;
            ST_FETCH: if (mem_ack) state_nx = chain ? ST_FETCH : ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_req = (state == ST_FETCH);
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_temp  <= '0;
            pend_temp <= '0;
            pend_vld  <= 1'b0;
            dac_code  <= '0;
            dac_valid <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (take) cur_temp <= temp_in;
                    pend_vld <= 1'b0;
                end
                ST_FETCH: begin
                    if (mem_ack) begin
                        if (chain) cur_temp <= take ? temp_in : pend_temp;
                        pend_vld <= 1'b0;
                    end else if (take) begin
                        pend_temp <= temp_in;
                        pend_vld  <= 1'b1;
                    end
                end
            endcase
            if (mem_req && mem_ack && out_en) begin
                dac_code  <= mem_rdata;
                dac_valid <= 1'b1;
            end else if (!out_en) begin
                dac_valid <= 1'b0;
            end
        end
    end

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req);
    // R6
    code_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dac_code) |-> $past(mem_req && mem_ack && out_en));
    // R6
    valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_valid) |-> $past(mem_ack && out_en));
    // R7
    off_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |=> !dac_valid);
    // R7
    idle_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_req && !out_en |=> !mem_req);
    // R8
    drop_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ack && !out_en |=> $stable(dac_code));
endmodule

// File: rtl/tmap_top.sv
module tmap_top
    import tmap_pkg::*;
#(
    parameter int TEMP_W    = TEMP_W_D,
    parameter int WORD_W    = WORD_W_D,
    parameter int SLOTS     = SLOTS_D,
    parameter int PAGE_BITS = PAGE_BITS_D,
    parameter int PAGE_CNT  = PAGE_CNT_D,
    parameter int LO_HALF   = LO_HALF_D,
    parameter int HI_HALF   = HI_HALF_D,
    parameter int SKEW      = SKEW_D
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           temp_valid,
    input  logic [TEMP_W-1:0]              temp_in,
    input  logic                           out_en,
    output logic                           mem_req,
    output logic [$clog2(PAGE_CNT)-1:0]    mem_page,
    output logic [$clog2(PAGE_BITS)-1:0]   mem_bitoff,
    input  logic                           mem_ack,
    input  logic [WORD_W-1:0]              mem_rdata,
    output logic [WORD_W-1:0]              dac_code,
    output logic                           dac_valid
);
    localparam int PG_W  = $clog2(PAGE_CNT);
    localparam int OFF_W = $clog2(PAGE_BITS);

    logic [TEMP_W-1:0] cur_temp;

    tmap_ctrl #(.TEMP_W(TEMP_W), .WORD_W(WORD_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .temp_valid (temp_valid),
        .temp_in    (temp_in),
        .out_en     (out_en),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .cur_temp   (cur_temp),
        .mem_req    (mem_req),
        .dac_code   (dac_code),
        .dac_valid  (dac_valid)
    );

    tmap_addr #(
        .TEMP_W (TEMP_W), .WORD_W (WORD_W), .SLOTS (SLOTS),
        .LO_HALF(LO_HALF), .HI_HALF(HI_HALF), .SKEW (SKEW),
        .PG_W   (PG_W), .OFF_W (OFF_W)
    ) u_addr (
        .temp    (cur_temp),
        .page    (mem_page),
        .bit_off (mem_bitoff)
    );

    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> $stable(mem_page) && $stable(mem_bitoff));
    // R3
    page_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_page < PG_W'(PAGE_CNT)) && (mem_bitoff <= OFF_W'((SLOTS-1)*WORD_W)));
    // R4
    first_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_page == '0 |-> mem_bitoff >= OFF_W'(SKEW*WORD_W));
    // R5
    last_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_page == PG_W'(PAGE_CNT-1) |-> mem_bitoff == '0);
endmodule

// File: tb/test_tmap_top.sv
module test_tmap_top;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_LAT    = 3;

    typedef struct {
        int         page;
        int         off;
        logic [9:0] code;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       temp_valid = 1'b0;
    logic [8:0] temp_in = '0;
    logic       out_en = 1'b1;
    logic       mem_req;
    logic [5:0] mem_page;
    logic [6:0] mem_bitoff;
    logic       mem_ack = 1'b0;
    logic [9:0] mem_rdata = '0;
    logic [9:0] dac_code;
    logic       dac_valid;

    int   checks = 0;
    int   fails  = 0;
    int   mcnt   = 0;
    exp_t sb[$];
    bit   due = 1'b0;
    exp_t due_item;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmap_top i_tmap_top (
        .clk(clk), .rst_n(rst_n), .temp_valid(temp_valid), .temp_in(temp_in),
        .out_en(out_en), .mem_req(mem_req), .mem_page(mem_page),
        .mem_bitoff(mem_bitoff), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .dac_code(dac_code), .dac_valid(dac_valid)
    );

    function automatic logic [9:0] mem_fn(int page, int off);
        return 10'((page * 37 + off * 5 + 3) & 1023);
    endfunction

    // memory model: acknowledges a held request after MEM_LAT cycles
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0; mcnt <= 0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0; mcnt <= 0;
        end else if (mem_req) begin
            if (mcnt == MEM_LAT - 1) begin
                mem_ack   <= 1'b1;
                mem_rdata <= mem_fn(int'(mem_page), int'(mem_bitoff));
                mcnt      <= 0;
            end else mcnt <= mcnt + 1;
        end else mcnt <= 0;
    end

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic exp_t expect_of(logic [8:0] t, string tag);
        exp_t e;
        int h = t[8] ? int'(t) - 512 : int'(t);
        int p;
        if (h < -50) h = -50;
        if (h > 200) h = 200;
        p = h + 56;
        e.page = p / 8;
        e.off  = (p % 8) * 10;
        e.code = mem_fn(e.page, e.off);
        e.tag  = tag;
        return e;
    endfunction

    // monitor: compares each completed fetch against the scoreboard
    always @(negedge clk) begin
        if (due) begin
            chk(dac_code == due_item.code, "R6 code", int'(dac_code), int'(due_item.code));
            chk(dac_valid == 1'b1, "R6 valid", int'(dac_valid), 1);
            due = 1'b0;
        end
        if (rst_n && mem_req && mem_ack && out_en) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R9 unexpected fetch", int'(mem_page), -1);
            end else begin
                due_item = sb.pop_front();
                chk(int'(mem_page) == due_item.page, {due_item.tag, " page"},
                    int'(mem_page), due_item.page);
                chk(int'(mem_bitoff) == due_item.off, {due_item.tag, " offset"},
                    int'(mem_bitoff), due_item.off);
                due = 1'b1;
            end
        end
    end

    task automatic pulse(logic [8:0] t, bit push, string tag);
        if (push) sb.push_back(expect_of(t, tag));
        temp_in    = t;
        temp_valid = 1'b1;
        @(negedge clk);
        temp_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (sb.size() != 0 || mem_req || due) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic send(logic [8:0] t, string tag);
        pulse(t, 1'b1, tag);
        chk(mem_req == 1'b1, "R2 request", int'(mem_req), 1);
        wait_idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [9:0] saved;
        bit saw_req;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dac_code == 10'd0, "R1 code", int'(dac_code), 0);
        chk(dac_valid == 1'b0, "R1 valid", int'(dac_valid), 0);
        chk(mem_req == 1'b0, "R1 req", int'(mem_req), 0);

        send(9'h1CE, "R3");
        send(9'h1CF, "R3");
        send(9'h1D0, "R3");
        send(9'h033, "R3");
        send(9'h0C8, "R3");
        send(9'h192, "R4");
        send(9'h1CD, "R4");
        send(9'h0FA, "R5");
        send(9'h0C9, "R5");

        // R9: three strobes inside one fetch; the middle one is superseded
        pulse(9'h010, 1'b1, "R9 first");
        pulse(9'h020, 1'b0, "R9");
        pulse(9'h030, 1'b1, "R9 latest");
        wait_idle();

        // R7: disabled output ignores new results
        out_en = 1'b0;
        @(negedge clk);
        chk(dac_valid == 1'b0, "R7 valid", int'(dac_valid), 0);
        saved = dac_code;
        pulse(9'h050, 1'b0, "R7");
        saw_req = 1'b0;
        for (int i = 0; i < 8; i++) begin
            if (mem_req) saw_req = 1'b1;
            @(negedge clk);
        end
        chk(saw_req == 1'b0, "R7 no fetch", int'(saw_req), 0);
        chk(dac_code == saved, "R7 code held", int'(dac_code), int'(saved));
        out_en = 1'b1;
        send(9'h040, "R7 re-enable");

        // R8: output disabled mid-fetch discards the word
        saved = dac_code;
        pulse(9'h060, 1'b0, "R8");
        out_en = 1'b0;
        while (mem_req) @(negedge clk);
        @(negedge clk);
        chk(dac_code == saved, "R8 code held", int'(dac_code), int'(saved));
        chk(dac_valid == 1'b0, "R8 valid", int'(dac_valid), 0);
        out_en = 1'b1;
        send(9'h061, "R8 recover");

        // R3 R4 R5: every input code
        for (int t = 0; t < 512; t++) begin
            send(9'(t), "R3 sweep");
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule